// File: doc/BRIEF.md
# DMA Channel Register Programming Port

This block is the processor-facing register file of a four-channel DMA engine. A host reaches it through a 16-location I/O window and an 8-bit data path. Each channel keeps a 16-bit start address and a 16-bit start count. Each channel also keeps a current address and a current count, which the transfer engine advances. Because the data path is only one byte wide, every 16-bit register is reached through a single offset. A shared internal byte pointer selects the low or the high half of the register. The host can force this pointer back to the low half by writing a dedicated offset.

The other offsets carry the control traffic: a command byte, per-channel transfer mode, software service requests, masking one channel at a time, clearing every mask, writing the whole mask, and a master clear. A status byte can be read back. The block exposes every register value to the transfer engine. It also produces a per-channel request vector in which masked channels stay silent, so software can reprogram a channel safely while it is masked. The engine reports each completed transfer on a one-cycle step strobe. On that strobe the current address counts up and the current count counts down.

Top module: `dmac_regport`

## Requirements
- R1: Offsets 0 to 7 hold the channel registers: offset 2n is channel n's address and offset 2n+1 is its count. A byte written there goes into the start register, and the current register takes the updated start value on the same clock edge.
- R2: One byte pointer serves all eight channel offsets. It is 0 after reset, selects the low byte (bits 7:0) when 0 and the high byte (bits 15:8) when 1, and flips on every byte read or write to offsets 0 to 7.
- R3: Any write to offset 0xC returns the byte pointer to 0, whatever the data.
- R4: A read of offset 2n or 2n+1 returns the selected byte of the current address or current count. A step pulse for channel n adds 1 to its current address and subtracts 1 (mod 2^16) from its current count, and leaves the start registers unchanged.
- R5: A write to offset 0xB sets the mode of the channel in data bits 1:0. Bit 2 is the direction (1 = memory to I/O, 0 = I/O to memory), and bits 4:3 are the transfer kind (0 single, 1 block, 2 demand, 3 cascade). chan_mode holds {kind, direction} in 3 bits per channel.
- R6: A write to offset 0xA sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel in data bits 1:0.
- R7: A write to offset 0xE clears all four masks. A write to offset 0xF loads all four masks from data bits 3:0.
- R8: A write to offset 0xD (master clear) sets all masks, clears the command byte, the software requests and the byte pointer, and leaves the channel registers and modes unchanged.
- R9: chan_req bit n is (dev_req[n] or software request n) and not mask n. A masked channel therefore ignores its request line.
- R10: A write to offset 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the software request of the channel in data bits 1:0.
- R11: A write to offset 8 stores the command byte on cmd_reg. A read of offset 8 returns status, with dev_req in bits 7:4 and the software requests in bits 3:0. Reads of offsets 9 to 0xF return 0.
- R12: After reset all masks are set and the command byte, software requests, modes, channel registers and byte pointer are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_sel | input | 1 | Window select |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe, one byte per cycle |
| io_addr | input | 4 | Offset in the window |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle of the read strobe |
| dev_req | input | 4 | Hardware request per channel |
| xfer_step | input | 4 | Per-channel transfer-completed pulse |
| chan_req | output | 4 | Requests of unmasked channels |
| chan_mask | output | 4 | Mask bits |
| cmd_reg | output | 8 | Command byte |
| chan_mode | output | 12 | {kind, direction} per channel, channel 0 lowest |
| base_addr_o | output | 64 | Start addresses, 16 bits per channel |
| base_cnt_o | output | 64 | Start counts |
| cur_addr_o | output | 64 | Current addresses |
| cur_cnt_o | output | 64 | Current counts |

## Verification
The bench uses the default build: four channels and an 8-bit port, so each register takes exactly two byte accesses and the status byte holds both request nibbles. With these values, directed cases can count a 0x0000 count down to 0xFFFF and carry 0x00FF to 0x0100. They can also desynchronise the pointer with a single byte and then recover it. The random phase mixes reads and writes to the same pointer with steps and mask traffic on every channel.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam logic [3:0] OFS_CMD     = 4'h8;
    localparam logic [3:0] OFS_SWREQ   = 4'h9;
    localparam logic [3:0] OFS_ONEMASK = 4'hA;
    localparam logic [3:0] OFS_MODE    = 4'hB;
    localparam logic [3:0] OFS_PTRCLR  = 4'hC;
    localparam logic [3:0] OFS_MCLR    = 4'hD;
    localparam logic [3:0] OFS_UNMASK  = 4'hE;
    localparam logic [3:0] OFS_ALLMASK = 4'hF;

    typedef enum logic [1:0] {
        XK_SINGLE  = 2'd0,
        XK_BLOCK   = 2'd1,
        XK_DEMAND  = 2'd2,
        XK_CASCADE = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       mem_to_io;
    } ch_mode_t;

    typedef struct packed {
        logic chreg_wr;
        logic chreg_rd;
        logic cmd_wr;
        logic swreq_wr;
        logic onemask_wr;
        logic mode_wr;
        logic ptrclr_wr;
        logic mclr_wr;
        logic unmask_wr;
        logic allmask_wr;
        logic status_rd;
    } strobe_t;

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic       sel,
    input  logic       wr,
    input  logic       rd,
    input  logic [3:0] addr,
    output strobe_t    stb
);

    localparam logic [3:0] CHREG_END = 4'(2 * NUM_CH);

    logic wr_acc;
    logic rd_acc;

    always_comb begin
        wr_acc = sel && wr;
        rd_acc = sel && rd && !wr;
        stb    = '0;
        if (addr < CHREG_END) begin
            stb.chreg_wr = wr_acc;
            stb.chreg_rd = rd_acc;
        end else begin
            unique case (addr)
                OFS_CMD: begin
                    stb.cmd_wr    = wr_acc;
                    stb.status_rd = rd_acc;
                end
                OFS_SWREQ:   stb.swreq_wr   = wr_acc;
                OFS_ONEMASK: stb.onemask_wr = wr_acc;
                OFS_MODE:    stb.mode_wr    = wr_acc;
                OFS_PTRCLR:  stb.ptrclr_wr  = wr_acc;
                OFS_MCLR:    stb.mclr_wr    = wr_acc;
                OFS_UNMASK:  stb.unmask_wr  = wr_acc;
                OFS_ALLMASK: stb.allmask_wr = wr_acc;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
    import dmac_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_addr,
    input  logic            we_cnt,
    input  logic            hi,
    input  logic [DW-1:0]   wdata,
    input  logic            step,
    input  logic            mode_we,
    input  ch_mode_t        mode_in,
    output logic [2*DW-1:0] base_addr,
    output logic [2*DW-1:0] base_cnt,
    output logic [2*DW-1:0] cur_addr,
    output logic [2*DW-1:0] cur_cnt,
    output ch_mode_t        mode
);

    localparam int RW = 2 * DW;

    typedef struct packed {
        logic [RW-1:0] base_a;
        logic [RW-1:0] base_c;
        logic [RW-1:0] cur_a;
        logic [RW-1:0] cur_c;
        ch_mode_t      mode;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [RW-1:0] new_a, new_c;

    always_comb begin
        st_d  = st_q;
        new_a = st_q.base_a;
        new_c = st_q.base_c;
        if (hi) begin
            new_a[RW-1:DW] = wdata;
            new_c[RW-1:DW] = wdata;
        end else begin
            new_a[DW-1:0] = wdata;
            new_c[DW-1:0] = wdata;
        end
        if (step) begin
            st_d.cur_a = st_q.cur_a + RW'(1);
            st_d.cur_c = st_q.cur_c - RW'(1);
        end
        if (we_addr) begin
            st_d.base_a = new_a;
            st_d.cur_a  = new_a;
        end
        if (we_cnt) begin
            st_d.base_c = new_c;
            st_d.cur_c  = new_c;
        end
        if (mode_we) begin
            st_d.mode = mode_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base_addr = st_q.base_a;
    assign base_cnt  = st_q.base_c;
    assign cur_addr  = st_q.cur_a;
    assign cur_cnt   = st_q.cur_c;
    assign mode      = st_q.mode;

    AST_CUR_TRACKS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        we_addr |=> cur_addr == base_addr); // R1

    AST_STEP_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !we_addr && !we_cnt) |=>
            (cur_addr == $past(cur_addr) + RW'(1)) && (cur_cnt == $past(cur_cnt) - RW'(1))); // R4

    AST_BASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_addr && !we_cnt) |=> $stable(base_addr) && $stable(base_cnt)); // R4

endmodule

// File: rtl/dmac_regport.sv
module dmac_regport
    import dmac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DW     = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_sel,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [3:0]             io_addr,
    input  logic [DW-1:0]          io_wdata,
    output logic [DW-1:0]          io_rdata,
    input  logic [NUM_CH-1:0]      dev_req,
    input  logic [NUM_CH-1:0]      xfer_step,
    output logic [NUM_CH-1:0]      chan_req,
    output logic [NUM_CH-1:0]      chan_mask,
    output logic [DW-1:0]          cmd_reg,
    output logic [NUM_CH*3-1:0]    chan_mode,
    output logic [NUM_CH*2*DW-1:0] base_addr_o,
    output logic [NUM_CH*2*DW-1:0] base_cnt_o,
    output logic [NUM_CH*2*DW-1:0] cur_addr_o,
    output logic [NUM_CH*2*DW-1:0] cur_cnt_o
);

    localparam int RW   = 2 * DW;
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic              ptr;
        logic [DW-1:0]     cmd;
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] swreq;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    strobe_t    stb;

    logic [CH_W-1:0] sel_ch;
    logic            sel_cnt;
    logic [CH_W-1:0] wd_ch;
    ch_mode_t        mode_in;
    logic [RW-1:0]   cur_a_w [NUM_CH];
    logic [RW-1:0]   cur_c_w [NUM_CH];
    logic [RW-1:0]   rd_word;

    assign sel_ch  = io_addr[CH_W:1];
    assign sel_cnt = io_addr[0];
    assign wd_ch   = io_wdata[CH_W-1:0];
    assign mode_in = ch_mode_t'({io_wdata[4:3], io_wdata[2]});

    dmac_decode #(.NUM_CH(NUM_CH)) u_decode (
        .sel  (io_sel),
        .wr   (io_wr),
        .rd   (io_rd),
        .addr (io_addr),
        .stb  (stb)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : gen_ch
        ch_mode_t mode_g;

        dmac_chan #(.DW(DW)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_addr   (stb.chreg_wr && (sel_ch == CH_W'(g)) && !sel_cnt),
            .we_cnt    (stb.chreg_wr && (sel_ch == CH_W'(g)) && sel_cnt),
            .hi        (ctl_q.ptr),
            .wdata     (io_wdata),
            .step      (xfer_step[g]),
            .mode_we   (stb.mode_wr && (wd_ch == CH_W'(g))),
            .mode_in   (mode_in),
            .base_addr (base_addr_o[g*RW +: RW]),
            .base_cnt  (base_cnt_o[g*RW +: RW]),
            .cur_addr  (cur_a_w[g]),
            .cur_cnt   (cur_c_w[g]),
            .mode      (mode_g)
        );

        assign cur_addr_o[g*RW +: RW] = cur_a_w[g];
        assign cur_cnt_o[g*RW +: RW]  = cur_c_w[g];
        assign chan_mode[g*3 +: 3]    = mode_g;
    end

    always_comb begin
        ctl_d = ctl_q;
        if (stb.chreg_wr || stb.chreg_rd) begin
            ctl_d.ptr = !ctl_q.ptr;
        end
        if (stb.ptrclr_wr) begin
            ctl_d.ptr = 1'b0;
        end
        if (stb.cmd_wr) begin
            ctl_d.cmd = io_wdata;
        end
        if (stb.swreq_wr) begin
            ctl_d.swreq[wd_ch] = io_wdata[2];
        end
        if (stb.onemask_wr) begin
            ctl_d.mask[wd_ch] = io_wdata[2];
        end
        if (stb.unmask_wr) begin
            ctl_d.mask = '0;
        end
        if (stb.allmask_wr) begin
            ctl_d.mask = io_wdata[NUM_CH-1:0];
        end
        if (stb.mclr_wr) begin
            ctl_d.ptr   = 1'b0;
            ctl_d.cmd   = '0;
            ctl_d.swreq = '0;
            ctl_d.mask  = '1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.mask  <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_ch == CH_W'(i)) begin
                rd_word = sel_cnt ? cur_c_w[i] : cur_a_w[i];
            end
        end
        io_rdata = '0;
        if (stb.chreg_rd) begin
            io_rdata = ctl_q.ptr ? rd_word[RW-1:DW] : rd_word[DW-1:0];
        end else if (stb.status_rd) begin
            io_rdata = DW'({dev_req, ctl_q.swreq});
        end
    end

    assign chan_req  = (dev_req | ctl_q.swreq) & ~ctl_q.mask;
    assign chan_mask = ctl_q.mask;
    assign cmd_reg   = ctl_q.cmd;

    AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        stb.mclr_wr |=> (chan_mask == '1) && (cmd_reg == '0) && !ctl_q.ptr); // R8

    AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        stb.ptrclr_wr |=> !ctl_q.ptr); // R3

    AST_PTR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.chreg_wr || stb.chreg_rd) |=> ctl_q.ptr != $past(ctl_q.ptr)); // R2

    AST_ALLMASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        stb.allmask_wr |=> chan_mask == $past(io_wdata[NUM_CH-1:0])); // R7

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_mask[0]) |-> !chan_req[0]); // R9

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel && io_rd && !io_wr && io_addr > OFS_CMD) |-> io_rdata == '0); // R11

endmodule

// File: tb/dmac_regport_tb.sv
`timescale 1ns/1ps
module dmac_regport_tb;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  dev_req = '0, xfer_step = '0;
    logic [3:0]  chan_req, chan_mask;
    logic [7:0]  cmd_reg;
    logic [11:0] chan_mode;
    logic [63:0] base_addr_o, base_cnt_o, cur_addr_o, cur_cnt_o;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] m_ba [NCH];
    logic [15:0] m_bc [NCH];
    logic [15:0] m_ca [NCH];
    logic [15:0] m_cc [NCH];
    logic [2:0]  m_mode [NCH];
    logic        m_ptr;
    logic [7:0]  m_cmd;
    logic [3:0]  m_mask, m_sw;

    always #2.5 clk = ~clk;

    dmac_regport u_dut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dev_req(dev_req), .xfer_step(xfer_step), .chan_req(chan_req),
        .chan_mask(chan_mask), .cmd_reg(cmd_reg), .chan_mode(chan_mode),
        .base_addr_o(base_addr_o), .base_cnt_o(base_cnt_o),
        .cur_addr_o(cur_addr_o), .cur_cnt_o(cur_cnt_o)
    );

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_ba[i] = '0; m_bc[i] = '0; m_ca[i] = '0; m_cc[i] = '0; m_mode[i] = '0;
        end
        m_ptr = 1'b0; m_cmd = '0; m_mask = 4'hF; m_sw = '0;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [7:0] d);
        int ch;
        ch = int'(d[1:0]);
        if (a < 4'h8) begin
            int c;
            c = int'(a[2:1]);
            if (a[0]) begin
                if (m_ptr) m_bc[c][15:8] = d; else m_bc[c][7:0] = d;
                m_cc[c] = m_bc[c];
            end else begin
                if (m_ptr) m_ba[c][15:8] = d; else m_ba[c][7:0] = d;
                m_ca[c] = m_ba[c];
            end
            m_ptr = !m_ptr;
        end else begin
            case (a)
                4'h8: m_cmd = d;
                4'h9: m_sw[ch] = d[2];
                4'hA: m_mask[ch] = d[2];
                4'hB: m_mode[ch] = {d[4:3], d[2]};
                4'hC: m_ptr = 1'b0;
                4'hD: begin m_ptr = 1'b0; m_cmd = '0; m_sw = '0; m_mask = 4'hF; end
                4'hE: m_mask = '0;
                default: m_mask = d[3:0];
            endcase
        end
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        logic [15:0] w;
        if (a < 4'h8) begin
            w = a[0] ? m_cc[a[2:1]] : m_ca[a[2:1]];
            model_read = m_ptr ? w[15:8] : w[7:0];
            m_ptr = !m_ptr;
        end else if (a == 4'h8) begin
            model_read = {dev_req, m_sw};
        end else begin
            model_read = 8'h00;
        end
    endfunction

    task automatic io_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_sel = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_sel = 1'b0; io_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic io_read(input logic [3:0] a, input string req);
        logic [7:0] got, exp;
        @(negedge clk);
        io_sel = 1'b1; io_rd = 1'b1; io_addr = a;
        #1;
        got = io_rdata;
        exp = model_read(a);
        check_eq(req, {24'h0, got}, {24'h0, exp});
        @(negedge clk);
        io_sel = 1'b0; io_rd = 1'b0;
    endtask

    task automatic pulse_step(input logic [3:0] m);
        @(negedge clk);
        xfer_step = m;
        @(negedge clk);
        xfer_step = '0;
        for (int i = 0; i < NCH; i++) begin
            if (m[i]) begin
                m_ca[i] = m_ca[i] + 16'd1;
                m_cc[i] = m_cc[i] - 16'd1;
            end
        end
    endtask

    task automatic check_outputs(input string tag);
        check_eq({tag, " R6 R7 mask"}, {28'h0, chan_mask}, {28'h0, m_mask});
        check_eq({tag, " R11 cmd"}, {24'h0, cmd_reg}, {24'h0, m_cmd});
        check_eq({tag, " R9 req"}, {28'h0, chan_req}, {28'h0, (dev_req | m_sw) & ~m_mask});
        for (int i = 0; i < NCH; i++) begin
            check_eq({tag, " R1 base_addr"}, {16'h0, base_addr_o[i*16 +: 16]}, {16'h0, m_ba[i]});
            check_eq({tag, " R1 base_cnt"}, {16'h0, base_cnt_o[i*16 +: 16]}, {16'h0, m_bc[i]});
            check_eq({tag, " R4 cur_addr"}, {16'h0, cur_addr_o[i*16 +: 16]}, {16'h0, m_ca[i]});
            check_eq({tag, " R4 cur_cnt"}, {16'h0, cur_cnt_o[i*16 +: 16]}, {16'h0, m_cc[i]});
            check_eq({tag, " R5 mode"}, {29'h0, chan_mode[i*3 +: 3]}, {29'h0, m_mode[i]});
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0DAC));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        @(negedge clk);
        check_eq("R12 mask after reset", {28'h0, chan_mask}, 32'hF);
        check_outputs("R12 reset");
        io_read(4'h0, "R12 R2 read low after reset");

        // R1 R2: two-byte load of channel 2 address
        io_write(4'h3, 8'h00); // leaves pointer back at low after read above toggled it
        io_write(4'hC, 8'h5A); // R3 pointer to low regardless of data
        io_write(4'h4, 8'h56);
        io_write(4'h4, 8'h34);
        check_eq("R1 ch2 base addr", {16'h0, base_addr_o[32 +: 16]}, 32'h3456);
        check_eq("R1 ch2 cur addr", {16'h0, cur_addr_o[32 +: 16]}, 32'h3456);

        // R3: desync with a single byte, then recover
        io_write(4'h5, 8'hAA);
        io_write(4'hC, 8'h00);
        io_write(4'h5, 8'h11);
        io_write(4'h5, 8'h22);
        check_eq("R3 ch2 count after pointer clear", {16'h0, base_cnt_o[32 +: 16]}, 32'h2211);

        // R2 shared pointer between write and read
        io_write(4'h0, 8'hEF);
        io_read(4'h0, "R2 read after one write gets high byte");
        io_write(4'hC, 8'h00);

        // R4 steps, including carry and count wrap
        io_write(4'h6, 8'hFF); io_write(4'h6, 8'h00);
        io_write(4'h7, 8'h00); io_write(4'h7, 8'h00);
        pulse_step(4'b1100);
        pulse_step(4'b0100);
        pulse_step(4'b0100);
        check_eq("R4 ch3 addr carry", {16'h0, cur_addr_o[48 +: 16]}, 32'h0100);
        check_eq("R4 ch3 count wraps", {16'h0, cur_cnt_o[48 +: 16]}, 32'hFFFF);
        check_eq("R4 ch2 base kept", {16'h0, base_addr_o[32 +: 16]}, 32'h3456);
        io_read(4'h4, "R4 ch2 current addr low");
        io_read(4'h4, "R4 ch2 current addr high");
        io_read(4'h5, "R4 ch2 remaining count low");
        io_read(4'h5, "R4 ch2 remaining count high");

        // R5 modes, R11 command
        io_write(4'hB, 8'b000_11_1_10);
        io_write(4'hB, 8'b000_01_0_01);
        io_write(4'h8, 8'hC3);
        check_outputs("R5 R11 directed");

        // R6 R9 R10 masking and requests
        io_write(4'hE, 8'h00);
        dev_req = 4'b0011;
        io_write(4'h9, 8'b0000_0110);
        io_write(4'hA, 8'b0000_0100);
        @(negedge clk);
        check_eq("R9 masked ch0 ignores request", {28'h0, chan_req}, 32'h6);
        io_read(4'h8, "R11 status byte");
        io_read(4'hA, "R11 unused read is zero");
        io_write(4'hF, 8'hF5);
        check_outputs("R7 all-mask write");

        // R8 master clear keeps channel registers
        io_write(4'h0, 8'h77);
        io_write(4'hD, 8'h00);
        check_outputs("R8 master clear");
        io_write(4'h1, 8'h99);
        check_eq("R8 pointer low after clear", {24'h0, base_cnt_o[7:0]}, 32'h99);

        // random phase
        for (int it = 0; it < 600; it++) begin
            int op;
            op = int'($urandom_range(0, 9));
            dev_req = 4'($urandom);
            case (op)
                0, 1, 2: io_write(4'($urandom_range(0, 7)), 8'($urandom));
                3, 4:    io_read(4'($urandom_range(0, 8)), "R2 R4 R11 random read");
                5:       pulse_step(4'($urandom));
                6:       io_write(4'($urandom_range(9, 11)), 8'($urandom));
                7:       io_write(4'($urandom_range(12, 15)), 8'($urandom));
                8:       io_write(4'h8, 8'($urandom));
                default: io_read(4'($urandom_range(9, 15)), "R11 random idle read");
            endcase
            @(negedge clk);
            check_outputs("random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule